// File: doc/BRIEF.md
# Dual-Edge SPI Master

This block is a serial-peripheral master that moves one 8-bit word in each direction per transfer. It talks to one slave among several. Each slave has its own active-low select wire, and no address is ever sent on the data lines. The host gives a start strobe, a transmit byte, a slave index and a 2-bit mode. One fixed span of system clocks after that, the block returns the received byte with a one-cycle done pulse. No acknowledgment is expected from the slave.

The serial clock comes from dividing the system clock. A parameter sets how many system clocks make up each half period. The sequencing logic, which drives the select lines and MOSI, advances only at falling serial-clock edges. A separate capture register shifts MISO in at rising edges.

Both edges follow one slave convention in every mode: the slave samples MOSI on a rising edge and changes MISO on a falling edge. The mode therefore does not move sampling between edges. It sets the idle level of the clock and the lead time between select and the first clock edge. Bit 0 of the mode is the polarity and bit 1 is the phase.

Top module: `spi_dual_edge_master`

## Requirements
- R1: While reset is held, every select line is high, `sck` is low, `done` is low and `rx_byte` is zero.
- R2: While no transfer is active, `sck` equals `mode[0]` one system clock after `mode` is applied: 0 for modes 0 and 2, 1 for modes 1 and 3.
- R3: `mode[1]` sets the lead time. The first `sck` transition comes 2·HALF_DIV system clocks after the clock edge that accepts `start` when `mode[1]`=0, and 3·HALF_DIV system clocks after it when `mode[1]`=1.
- R4: During a transfer, only `ssn[slave_sel]` is low, and it stays the same line for the whole transfer. All other select lines stay high.
- R5: MOSI carries `tx_byte` most significant bit first. Bit 7 is present when the select line falls, and MOSI changes only at falling `sck` edges. A slave sampling at the 8 rising edges sees `tx_byte`.
- R6: MISO is captured at rising `sck` edges, most significant bit first. `rx_byte` holds the 8 captured bits from the cycle that `done` is high.
- R7: Each transfer has exactly 8 rising and 8 falling `sck` edges. `sck` ends at the idle level of the mode latched at start.
- R8: `done` is high for exactly one system clock. It rises in the same cycle the select line returns high, HALF_DIV system clocks after the last `sck` transition. `rx_byte` then holds its value until the next `done`.
- R9: A `start` strobe during a transfer is ignored. It changes no select line and starts no later transfer.
- R10: A `start` strobe in the cycle where `done` is high is accepted. The new slave's select line falls on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| tx_byte | input | WORD | Byte to send, sampled with start |
| slave_sel | input | SEL_W | Index of the slave to select |
| mode | input | 2 | Bit 0 clock polarity, bit 1 clock phase |
| rx_byte | output | WORD | Last byte received |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ssn | output | NUM_SLAVES | Active-low select, one per slave |

## Verification
Two events can land on the same system clock: the end-of-transfer pulse, which also releases the select line, and a new start strobe. The bench waits for `done`, then raises `start` for a different slave in that very cycle. It expects the first transfer to close normally and the second to run in full, with its own bytes and select line. A second case puts a start strobe in the middle of a transfer. The bench then expects the active select line never to change, exactly one completion, and no further select activity afterwards.

// File: rtl/spi_dem_pkg.sv
// Package: shared types for the dual-edge SPI master.
// Assumes mode bit 0 is clock polarity and mode bit 1 is clock phase.
package spi_dem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_XFER = 2'd2,
        ST_TAIL = 2'd3
    } xfer_state_t;

    // Idle level of the serial clock for a mode
    function automatic logic mode_cpol(input logic [1:0] m);
        return m[0];
    endfunction

    // Extra half-period lead before the first clock edge
    function automatic logic mode_cpha(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
// Serial clock generator: a half-period timer that issues a tick every
// HALF_DIV system clocks while enabled. It toggles sck on ticks when
// toggling is allowed, and it flags which kind of edge each toggle is.
// Assumes HALF_DIV >= 1. While disabled, sck tracks the idle level.
module spi_sck_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic toggle_en,
    input  logic idle_lvl,
    output logic tick,
    output logic rise_evt,
    output logic fall_evt,
    output logic sck
);
    localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [TW-1:0] tmr_q;

    assign tick     = en && (tmr_q == TW'(HALF_DIV - 1));
    assign rise_evt = tick && toggle_en && !sck;
    assign fall_evt = tick && toggle_en && sck;

    // Half-period timer, restarted on every tick and held while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) tmr_q <= '0;
        else                       tmr_q <= tmr_q + 1'b1;
    end

    // Serial clock register: idle level when off, toggles on allowed ticks
    always_ff @(posedge clk) begin
        if (!rst_n)                 sck <= 1'b0;
        else if (!en)               sck <= idle_lvl;
        else if (tick && toggle_en) sck <= ~sck;
    end

endmodule

// File: rtl/spi_tx_fsm.sv
// Transfer sequencer: accepts start when idle, lowers one select line,
// holds MOSI most significant bit first, and shifts it on falling sck
// edges only. It counts 2*WORD sck transitions and closes the transfer
// one tick later with a done pulse. Assumes tick and the edge flags come
// from spi_sck_gen, and that the edge flags fire only in ST_XFER.
module spi_tx_fsm
    import spi_dem_pkg::*;
#(
    parameter int WORD       = 8,
    parameter int NUM_SLAVES = 4,
    parameter int SEL_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [WORD-1:0]       tx_byte,
    input  logic [SEL_W-1:0]      slave_sel,
    input  logic [1:0]            mode,
    input  logic                  tick,
    input  logic                  rise_evt,
    input  logic                  fall_evt,
    input  logic                  sck_i,
    output xfer_state_t           state,
    output logic [1:0]            mode_q,
    output logic [NUM_SLAVES-1:0] ssn,
    output logic                  mosi,
    output logic                  done
);
    localparam int EW = $clog2(2 * WORD);

    logic [NUM_SLAVES-1:0] sel_hit;
    logic [WORD-1:0]       tx_sh;
    logic [EW-1:0]         edge_cnt;
    logic                  lead_ph;

    // One-hot decode of the requested slave index
    for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_sel
        assign sel_hit[g] = (slave_sel == SEL_W'(g));
    end

    assign mosi = tx_sh[WORD-1];

    // Main sequencer: select, lead, serial exchange, tail and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_q   <= 2'b00;
            ssn      <= '1;
            tx_sh    <= '0;
            edge_cnt <= '0;
            lead_ph  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_LEAD;
                    mode_q   <= mode;
                    tx_sh    <= tx_byte;
                    edge_cnt <= '0;
                    lead_ph  <= 1'b0;
                    ssn      <= ~sel_hit;
                end
                ST_LEAD: if (tick) begin
                    if (lead_ph == mode_cpha(mode_q)) state <= ST_XFER;
                    else                             lead_ph <= 1'b1;
                end
                ST_XFER: if (rise_evt || fall_evt) begin
                    edge_cnt <= edge_cnt + 1'b1;
                    if (fall_evt && edge_cnt != '0) tx_sh <= tx_sh << 1;
                    if (edge_cnt == EW'(2 * WORD - 1)) state <= ST_TAIL;
                end
                ST_TAIL: if (tick) begin
                    state <= ST_IDLE;
                    ssn   <= '1;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) && !fall_evt |=> $stable(mosi));
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) && start |=> $stable(ssn));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    tail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> (sck_i == mode_cpol(mode_q)));

endmodule

// File: rtl/spi_rx_capture.sv
// Receive path: shifts MISO in at rising sck edges, most significant bit
// first, and copies the word to the output when the transfer closes.
// Assumes exactly WORD rising edges occur between two loads.
module spi_rx_capture #(
    parameter int WORD = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise_evt,
    input  logic            load,
    input  logic            miso,
    output logic [WORD-1:0] rx_byte
);
    logic [WORD-1:0] shift_q;

    // Capture register, advanced only on rising serial clock edges
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (rise_evt) shift_q <= {shift_q[WORD-2:0], miso};
    end

    // Output holding register, updated once per completed transfer
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_byte <= '0;
        else if (load) rx_byte <= shift_q;
    end

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_evt |=> $stable(shift_q));

endmodule

// File: rtl/spi_dual_edge_master.sv
// Top level of the dual-edge SPI master. It wires the clock generator,
// the falling-edge sequencer and the rising-edge capture together. The
// idle clock level follows the live mode input between transfers and the
// latched mode during one. Assumes miso is synchronous to clk.
module spi_dual_edge_master
    import spi_dem_pkg::*;
#(
    parameter  int NUM_SLAVES = 4,
    parameter  int HALF_DIV   = 2,
    parameter  int WORD       = 8,
    localparam int SEL_W      = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [WORD-1:0]       tx_byte,
    input  logic [SEL_W-1:0]      slave_sel,
    input  logic [1:0]            mode,
    output logic [WORD-1:0]       rx_byte,
    output logic                  done,
    output logic                  sck,
    output logic                  mosi,
    input  logic                  miso,
    output logic [NUM_SLAVES-1:0] ssn
);
    xfer_state_t state;
    logic [1:0]  mode_q;
    logic        tick, rise_evt, fall_evt;
    logic        gen_en, gen_toggle, idle_lvl, finish;

    assign gen_en     = (state != ST_IDLE);
    assign gen_toggle = (state == ST_XFER);
    assign idle_lvl   = (state == ST_IDLE) ? mode_cpol(mode) : mode_cpol(mode_q);
    assign finish     = (state == ST_TAIL) && tick;

    spi_sck_gen #(.HALF_DIV(HALF_DIV)) sck_gen_i (
        .clk(clk), .rst_n(rst_n), .en(gen_en), .toggle_en(gen_toggle),
        .idle_lvl(idle_lvl), .tick(tick), .rise_evt(rise_evt),
        .fall_evt(fall_evt), .sck(sck)
    );

    spi_tx_fsm #(.WORD(WORD), .NUM_SLAVES(NUM_SLAVES), .SEL_W(SEL_W)) tx_fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .slave_sel(slave_sel), .mode(mode), .tick(tick), .rise_evt(rise_evt),
        .fall_evt(fall_evt), .sck_i(sck), .state(state), .mode_q(mode_q),
        .ssn(ssn), .mosi(mosi), .done(done)
    );

    spi_rx_capture #(.WORD(WORD)) rx_cap_i (
        .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .load(finish),
        .miso(miso), .rx_byte(rx_byte)
    );

    // R4
    one_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ssn));
    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&ssn));

endmodule

// File: tb/spi_dual_edge_master_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected transfers, the monitor
// models the slave and compares every completed transfer.
module spi_dual_edge_master_tb_top;
    localparam int NS = 4;
    localparam int H  = 2;

    typedef struct packed {
        logic [7:0] tx;
        logic [7:0] resp;
        logic [1:0] sel;
        logic [1:0] md;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    tx_byte = '0;
    logic [1:0]    slave_sel = '0;
    logic [1:0]    mode = '0;
    logic [7:0]    rx_byte;
    logic          done;
    logic          sck;
    logic          mosi;
    logic          miso = 1'b0;
    logic [NS-1:0] ssn;

    int    n_chk = 0;
    int    n_bad = 0;
    item_t exp_q[$];

    always #2 clk = ~clk;

    spi_dual_edge_master #(.NUM_SLAVES(NS), .HALF_DIV(H), .WORD(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .slave_sel(slave_sel), .mode(mode), .rx_byte(rx_byte), .done(done),
        .sck(sck), .mosi(mosi), .miso(miso), .ssn(ssn)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor and slave model, sampled away from the active edge
    logic       prev_sck = 1'b0, prev_done = 1'b0, active = 1'b0, got_lat = 1'b0;
    logic [NS-1:0] prev_ssn = '1, ssn_at = '1;
    logic [7:0] cap = '0, cur_resp = '0;
    int         nr = 0, nf = 0, lat = 0, first_lat = 0, since_edge = 0, sel_seen = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sck = sck; prev_ssn = ssn; prev_done = done; active = 1'b0;
        end else begin
            if ((&prev_ssn) && !(&ssn)) begin
                active = 1'b1; ssn_at = ssn; nr = 0; nf = 0; cap = '0;
                lat = 1; got_lat = 1'b0; since_edge = 0;
                for (int i = 0; i < NS; i++) if (!ssn[i]) sel_seen = i;
                cur_resp = (exp_q.size() > 0) ? exp_q[0].resp : 8'h00;
                miso = cur_resp[7];
            end else if (active) begin
                if (!got_lat) lat++;
                since_edge++;
                if (!(&ssn) && ssn != ssn_at)
                    chk(1'b0, "R4", "select changed mid transfer", int'(ssn), int'(ssn_at));
                if (sck != prev_sck) begin
                    since_edge = 0;
                    if (!got_lat) begin got_lat = 1'b1; first_lat = lat; end
                    if (sck) begin
                        cap = {cap[6:0], mosi}; nr++;
                    end else begin
                        nf++;
                        if (nr > 0 && nr < 8) miso = cur_resp[7 - nr];
                    end
                end
            end
            if (prev_done && done) chk(1'b0, "R8", "done wider than one cycle", 1, 0);
            if (done) begin
                chk(&ssn, "R8", "select released with done", int'(ssn), (1 << NS) - 1);
                chk(since_edge == H, "R8", "done delay after last edge", since_edge, H);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(rx_byte == it.resp, "R6", "received byte", rx_byte, it.resp);
                    chk(cap == it.tx, "R5", "byte seen by slave", cap, it.tx);
                    chk(sel_seen == int'(it.sel), "R4", "selected slave", sel_seen, it.sel);
                    chk(nr == 8 && nf == 8, "R7", "edge count r*100+f", nr * 100 + nf, 808);
                    chk(sck == it.md[0], "R7", "final sck level", sck, it.md[0]);
                    chk(first_lat == (2 + it.md[1]) * H + 1, "R3", "lead to first edge",
                        first_lat, (2 + it.md[1]) * H + 1);
                end
                active = 1'b0;
            end
            prev_sck = sck; prev_ssn = ssn; prev_done = done;
        end
    end

    // Driver: call at a negedge; raises start for one cycle
    task automatic kick(input logic [7:0] tx, input logic [7:0] resp,
                        input logic [1:0] sel, input logic [1:0] md, input bit push);
        item_t it;
        it.tx = tx; it.resp = resp; it.sel = sel; it.md = md;
        if (push) exp_q.push_back(it);
        tx_byte = tx; slave_sel = sel; mode = md; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic run_tests();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(&ssn, "R1", "ssn in reset", int'(ssn), (1 << NS) - 1);
        chk(sck == 1'b0 && done == 1'b0, "R1", "sck/done in reset", {sck, done}, 0);
        chk(rx_byte == 8'h00, "R1", "rx_byte in reset", rx_byte, 0);
        rst_n = 1'b1;
        // R2 idle level follows mode
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            repeat (2) @(negedge clk);
            chk(sck == mode[0], "R2", "idle sck level", sck, mode[0]);
            chk(&ssn, "R2", "idle select lines", int'(ssn), (1 << NS) - 1);
        end
        // Transfers across modes and slaves
        kick(8'hA5, 8'h3C, 2'd0, 2'd0, 1'b1); wait_done(); repeat (3) @(negedge clk);
        kick(8'h81, 8'h7E, 2'd1, 2'd1, 1'b1); wait_done(); repeat (3) @(negedge clk);
        kick(8'h5A, 8'hC3, 2'd2, 2'd2, 1'b1); wait_done(); repeat (3) @(negedge clk);
        kick(8'hFF, 8'h00, 2'd3, 2'd3, 1'b1); wait_done(); repeat (3) @(negedge clk);
        kick(8'h00, 8'hFF, 2'd0, 2'd3, 1'b1); wait_done(); repeat (3) @(negedge clk);
        // R9 start during a transfer is ignored
        kick(8'h96, 8'h69, 2'd2, 2'd0, 1'b1);
        repeat (10) @(negedge clk);
        kick(8'h11, 8'hEE, 2'd1, 2'd3, 1'b0);
        wait_done();
        repeat (20) @(negedge clk);
        chk(&ssn, "R9", "no transfer after ignored start", int'(ssn), (1 << NS) - 1);
        chk(exp_q.size() == 0, "R9", "pending items", exp_q.size(), 0);
        chk(rx_byte == 8'h69, "R8", "rx_byte held after done", rx_byte, 8'h69);
        mode = 2'd0;
        repeat (2) @(negedge clk);
        // R10 start in the done cycle is accepted
        kick(8'h3C, 8'hA7, 2'd1, 2'd2, 1'b1);
        wait_done();
        kick(8'hC8, 8'h1B, 2'd3, 2'd1, 1'b1);
        chk(ssn == 4'b0111, "R10", "new select after done-cycle start", int'(ssn), 4'b0111);
        wait_done();
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R10", "all transfers completed", exp_q.size(), 0);
    endtask

    initial begin
        fork
            begin run_tests(); end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule